// File: doc/BRIEF.md
# Poison-Aware Replacement Picker for One Cache Set

This block chooses which way of a single last-level cache set gets replaced on a miss. Some lines may hold data that has not yet passed its integrity check. Each way carries a poison flag, and the block stores these flags itself. A flag is raised when the way receives a speculative fill, or when a store whose data is poisoned hits that way. A verification-complete pulse clears every flag at once.

A way that is valid, dirty and poisoned is locked. Writing it back would send unverified data off chip, so replacement skips it. Among the other ways, an empty way wins. Otherwise the way with the oldest supplied recency rank wins.

When a request finds every way locked, the block raises a registered stall flag. The flag stays up until the next clear pulse. The clear also unlocks the set, so the retried request can then be served. A clean poisoned way may be chosen. It is dropped without a write-back, and the write-back flag marks only the dirty victims that need one.

Top module: `llc_victim_pick`

## Requirements
- R1: After reset, `poison_bits` is all zero and `evict_stall` is 0.
- R2: `fill_spec` high at a clock edge sets `poison_bits[fill_way]` from the next cycle on.
- R3: `store_poison_hit` high at a clock edge sets `poison_bits[store_way]` from the next cycle on.
- R4: `verify_clr` at a clock edge clears every poison bit. A fill or store-hit set in the same cycle still takes effect, so the set wins over the clear for that way.
- R5: A way that is valid, dirty and poisoned (locked) is never reported as the victim.
- R6: If any way is invalid, the victim is the lowest-numbered invalid way.
- R7: With no invalid way, the victim is the unlocked way with the smallest rank. Rank 0 means least recently used, and way i's rank is `lru_rank[3*i +: 3]` at default width. Ties go to the lower way number.
- R8: `victim_ok` is high only when `pick_req` is high and at least one way is unlocked. It is combinational, in the same cycle as the request.
- R9: A request that finds every way locked sets `evict_stall` at the next edge. The flag stays set until an edge with `verify_clr` high, and is 0 after that edge.
- R10: `victim_wb` is high exactly when `victim_ok` is high and the chosen way is valid and dirty. A clean poisoned victim therefore gives `victim_wb` = 0.
- R11: When `victim_ok` is 0, `victim_way` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pick_req | input | 1 | Request for a replacement way this cycle |
| way_valid | input | WAYS | Per-way valid bits |
| way_dirty | input | WAYS | Per-way dirty bits |
| lru_rank | input | WAYS*RANK_W | Per-way recency rank, 0 = oldest |
| fill_spec | input | 1 | Speculative fill into `fill_way` |
| fill_way | input | RANK_W | Way receiving the speculative fill |
| store_poison_hit | input | 1 | Poisoned store writes `store_way` |
| store_way | input | RANK_W | Way written by the poisoned store |
| verify_clr | input | 1 | All outstanding verifications done; flash clear |
| victim_way | output | RANK_W | Chosen way |
| victim_ok | output | 1 | Chosen way is valid for this request |
| victim_wb | output | 1 | Chosen way needs a write-back |
| evict_stall | output | 1 | Registered: set fully locked, wait for clear |
| poison_bits | output | WAYS | Stored per-way poison flags |

## Verification
The bench builds the block with its defaults: 8 ways and 3-bit ranks. At this size a fully locked set takes few fill pulses to reach, and rank ties show up often in random traffic. Random cycles use a high dirty density and rare clear pulses, so poison builds up and the stall-and-release path is exercised many times. Directed cases cover a set-and-clear collision in the same cycle, a clean poisoned victim, and an empty way beating an older occupied one.

// File: rtl/llc_victim_pick.sv
module llc_victim_pick #(
  parameter int WAYS   = 8,
  parameter int RANK_W = $clog2(WAYS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     pick_req,
  input  logic [WAYS-1:0]          way_valid,
  input  logic [WAYS-1:0]          way_dirty,
  input  logic [WAYS*RANK_W-1:0]   lru_rank,
  input  logic                     fill_spec,
  input  logic [RANK_W-1:0]        fill_way,
  input  logic                     store_poison_hit,
  input  logic [RANK_W-1:0]        store_way,
  input  logic                     verify_clr,
  output logic [RANK_W-1:0]        victim_way,
  output logic                     victim_ok,
  output logic                     victim_wb,
  output logic                     evict_stall,
  output logic [WAYS-1:0]          poison_bits
);

  logic [WAYS-1:0]   poison_q, locked, set_mask;
  logic              stall_q, inv_hit, old_hit, any_free;
  logic [RANK_W-1:0] inv_idx, old_idx, old_rank, pick_idx;

  assign locked = way_valid & way_dirty & poison_q;

  always_comb begin
    set_mask = '0;
    if (fill_spec)        set_mask[fill_way]  = 1'b1;
    if (store_poison_hit) set_mask[store_way] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          poison_q <= '0;
    else if (verify_clr) poison_q <= set_mask;
    else                 poison_q <= poison_q | set_mask;
  end

  always_comb begin
    inv_hit = 1'b0;
    inv_idx = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (!inv_hit && !way_valid[i]) begin
        inv_hit = 1'b1;
        inv_idx = RANK_W'(i);
      end
    end
  end

  always_comb begin
    old_hit  = 1'b0;
    old_idx  = '0;
    old_rank = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (way_valid[i] && !locked[i] &&
          (!old_hit || lru_rank[i*RANK_W +: RANK_W] < old_rank)) begin
        old_hit  = 1'b1;
        old_idx  = RANK_W'(i);
        old_rank = lru_rank[i*RANK_W +: RANK_W];
      end
    end
  end

  assign any_free = inv_hit | old_hit;
  assign pick_idx = inv_hit ? inv_idx : old_idx;

  always_ff @(posedge clk) begin
    if (!rst_n)          stall_q <= 1'b0;
    else if (verify_clr) stall_q <= 1'b0;
    else if (pick_req && !any_free) stall_q <= 1'b1;
  end

  assign victim_ok   = pick_req & any_free;
  assign victim_way  = victim_ok ? pick_idx : '0;
  assign victim_wb   = victim_ok & way_valid[pick_idx] & way_dirty[pick_idx];
  assign evict_stall = stall_q;
  assign poison_bits = poison_q;

endmodule

// File: rtl/llc_victim_pick_chk.sv
module llc_victim_pick_chk #(
  parameter int WAYS   = 8,
  parameter int RANK_W = $clog2(WAYS)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   pick_req,
  input logic [WAYS-1:0]        way_valid,
  input logic [WAYS-1:0]        way_dirty,
  input logic                   fill_spec,
  input logic [RANK_W-1:0]      fill_way,
  input logic                   store_poison_hit,
  input logic                   verify_clr,
  input logic [RANK_W-1:0]      victim_way,
  input logic                   victim_ok,
  input logic                   victim_wb,
  input logic                   evict_stall,
  input logic [WAYS-1:0]        poison_bits
);

  AST_NO_LOCKED_PICK: assert property (@(posedge clk) disable iff (!rst_n)
    victim_ok |-> !(way_valid[victim_way] && way_dirty[victim_way] && poison_bits[victim_way])); // R5

  AST_EMPTY_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (victim_ok && !(&way_valid)) |-> !way_valid[victim_way]); // R6

  AST_OK_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    victim_ok |-> pick_req); // R8

  AST_FILL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    fill_spec |=> poison_bits[$past(fill_way)]); // R2

  AST_FLASH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (verify_clr && !fill_spec && !store_poison_hit) |=> (poison_bits == '0)); // R4

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (evict_stall && !verify_clr) |=> evict_stall); // R9

  AST_STALL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    verify_clr |=> !evict_stall); // R9

  AST_CLEAN_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
    (victim_ok && !way_dirty[victim_way]) |-> !victim_wb); // R10

  AST_IDLE_WAY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !victim_ok |-> (victim_way == '0 && !victim_wb)); // R11

endmodule

bind llc_victim_pick llc_victim_pick_chk #(.WAYS(WAYS), .RANK_W(RANK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pick_req(pick_req), .way_valid(way_valid),
  .way_dirty(way_dirty), .fill_spec(fill_spec), .fill_way(fill_way),
  .store_poison_hit(store_poison_hit), .verify_clr(verify_clr),
  .victim_way(victim_way), .victim_ok(victim_ok), .victim_wb(victim_wb),
  .evict_stall(evict_stall), .poison_bits(poison_bits)
);

// File: tb/llc_victim_pick_test.sv
`timescale 1ns/1ps
module llc_victim_pick_test;
  localparam int W = 8;
  localparam int RW = 3;

  logic clk = 0, rst_n = 0;
  logic pick_req = 0, fill_spec = 0, store_poison_hit = 0, verify_clr = 0;
  logic [W-1:0] way_valid = '0, way_dirty = '0;
  logic [W*RW-1:0] lru_rank = '0;
  logic [RW-1:0] fill_way = '0, store_way = '0;
  logic [RW-1:0] victim_way;
  logic victim_ok, victim_wb, evict_stall;
  logic [W-1:0] poison_bits;

  int checks = 0, errors = 0;
  logic [W-1:0] m_poison = '0;
  logic m_stall = 0;

  always #4 clk = ~clk;

  llc_victim_pick uut (
    .clk(clk), .rst_n(rst_n), .pick_req(pick_req), .way_valid(way_valid),
    .way_dirty(way_dirty), .lru_rank(lru_rank), .fill_spec(fill_spec),
    .fill_way(fill_way), .store_poison_hit(store_poison_hit), .store_way(store_way),
    .verify_clr(verify_clr), .victim_way(victim_way), .victim_ok(victim_ok),
    .victim_wb(victim_wb), .evict_stall(evict_stall), .poison_bits(poison_bits)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // returns {ok, wb, way}
  function automatic logic [4:0] model_pick(input logic [W-1:0] v, d, p,
                                            input logic [W*RW-1:0] r, input logic req);
    logic found = 0;
    logic [RW-1:0] way = '0, best = '0;
    for (int i = 0; i < W; i++)
      if (!found && !v[i]) begin found = 1; way = RW'(i); end
    if (!found)
      for (int i = 0; i < W; i++)
        if (v[i] && !(d[i] && p[i]) && (!found || r[i*RW +: RW] < best)) begin
          found = 1; way = RW'(i); best = r[i*RW +: RW];
        end
    if (!(req && found)) return 5'b0;
    return {1'b1, v[way] & d[way], way};
  endfunction

  function automatic logic all_locked(input logic [W-1:0] v, d, p);
    return &(v & d & p);
  endfunction

  // one cycle: inputs already set at negedge; check comb, then edge, then regs
  task automatic cycle(input string tag);
    logic [4:0] e;
    logic [W-1:0] setm;
    #1;
    e = model_pick(way_valid, way_dirty, m_poison, lru_rank, pick_req);
    check({tag, " R8 ok"}, victim_ok, e[4]);
    check({tag, " R5/R6/R7/R11 way"}, victim_way, e[2:0]);
    check({tag, " R10 wb"}, victim_wb, e[3]);
    setm = '0;
    if (fill_spec) setm[fill_way] = 1;
    if (store_poison_hit) setm[store_way] = 1;
    if (verify_clr) m_stall = 0;
    else if (pick_req && all_locked(way_valid, way_dirty, m_poison)) m_stall = 1;
    m_poison = verify_clr ? setm : (m_poison | setm);
    @(posedge clk); #1;
    check({tag, " R2/R3/R4 poison"}, poison_bits, m_poison);
    check({tag, " R9 stall"}, evict_stall, m_stall);
    @(negedge clk);
    fill_spec = 0; store_poison_hit = 0; verify_clr = 0; pick_req = 0;
  endtask

  function automatic logic [W*RW-1:0] perm_rank();
    logic [W*RW-1:0] r;
    for (int i = 0; i < W; i++) r[i*RW +: RW] = RW'(W-1-i);
    return r;
  endfunction

  initial begin
    #(200000*8);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (3) @(posedge clk);
    #1;
    check("R1 poison reset", poison_bits, 0);
    check("R1 stall reset", evict_stall, 0);
    @(negedge clk); rst_n = 1;

    // R2 fill, R3 store
    way_valid = '1; way_dirty = '1; lru_rank = perm_rank();
    fill_spec = 1; fill_way = 3; cycle("R2");
    store_poison_hit = 1; store_way = 5; cycle("R3");
    // R7: all dirty, way 7 has rank 0 and is unlocked
    pick_req = 1; cycle("R7");
    // lock way 7, now way 6 oldest
    fill_spec = 1; fill_way = 7; cycle("R2b");
    pick_req = 1; cycle("R7b");
    // R6: invalid way beats older occupied
    way_valid = 8'b1101_1011; pick_req = 1; cycle("R6");
    way_valid = '1;
    // R10: clean poisoned way 7 chosen, no write-back
    way_dirty = 8'b0111_1111; pick_req = 1; cycle("R10");
    way_dirty = '1;
    // lock everything -> R9 stall
    for (int i = 0; i < W; i++) begin fill_spec = 1; fill_way = RW'(i); cycle("R2c"); end
    pick_req = 1; cycle("R9 set");
    pick_req = 1; cycle("R9 hold");
    cycle("R9 hold2");
    // R4 clear with same-cycle fill on way 2
    verify_clr = 1; fill_spec = 1; fill_way = 2; cycle("R4");
    pick_req = 1; cycle("R9 release");

    // random phase
    for (int n = 0; n < 4000; n++) begin
      way_valid = ($urandom % 8 == 0) ? W'($urandom) : '1;
      way_dirty = (n < 2000) ? ~(W'($urandom) & W'($urandom) & W'($urandom)) : W'($urandom);
      lru_rank  = (W*RW)'($urandom);
      pick_req  = ($urandom % 4) != 0;
      fill_spec = ($urandom % 3) == 0; fill_way = RW'($urandom);
      store_poison_hit = ($urandom % 4) == 0; store_way = RW'($urandom);
      verify_clr = ($urandom % 40) == 0;
      cycle("rand");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule